// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one configuration register that is replicated across a set of hardware units. The units are arranged as groups, each holding a fixed number of instances, and every copy of the register sits behind the same bus address while keeping its own value. A steering selector, reachable at its own address on the same bus, names one group and one instance and carries a broadcast bit. Writes to the shared data address either reach every unit (broadcast) or only the steered unit. Reads of the data address always come from the steered unit.

A per-unit presence mask comes in from outside and marks units that are fused off or power gated. Accesses steered to a missing unit are terminated without any error: reads return zero and writes are dropped. Several bus agents share the selector. A hardware semaphore decides which agent may change it. Reading the semaphore while it is free returns 1 and hands ownership to the reader. The owner gives ownership back by writing 1. An agent that wants a broadcast write must set the broadcast bit itself first, because the previous owner may have left the selector in unicast mode.

The bus uses a single-cycle register protocol with no back-pressure. A request is accepted in every cycle where `bus_req` is high. For each read, `bus_rvalid` pulses exactly one cycle later with the data.

Top module: `mcr_bank`

## Requirements
- R1: After reset the selector reads 0x8000_0000 (broadcast on, group 0, instance 0), the semaphore is free, and every unit's copy is zero.
- R2: Selector word layout: instance ID in bits [INST_BITS-1:0], group ID in bits [8+GRP_BITS-1:8], broadcast bit in bit 31; all other bits read as zero. Any agent can read the selector at address 1. Address 0 is the replicated data register, address 2 is the semaphore and address 3 is reserved.
- R3: A selector write changes the selector only when the writing agent owns the semaphore. Selector writes from any other agent leave it unchanged.
- R4: A semaphore read returns 1 while the semaphore is free and makes the reading agent the owner. While the semaphore is held, every semaphore read returns 0, including a read by the owner.
- R5: A semaphore write of exactly 1 by the owner frees the semaphore. Writes from other agents, and writes of any other value, have no effect.
- R6: A data write with the broadcast bit set stores the data into every present unit. The unit index is group*INSTS_PER_GROUP + instance.
- R7: A data write with the broadcast bit clear stores the data only into the steered unit.
- R8: A data read returns the steered unit's copy whatever the broadcast bit says.
- R9: A data read steered to an absent unit returns zero.
- R10: A unicast write steered to an absent unit is dropped. A broadcast write leaves absent units unchanged, and their stored value is visible again once the unit is present.
- R11: `bus_rvalid` is high in the cycle after each read request and low otherwise. `bus_rdata` is zero whenever `bus_rvalid` is low. Reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 selector, 2 semaphore, 3 reserved |
| bus_wdata | input | DATA_W | Write data |
| bus_agent | input | AGENT_W | ID of the requesting agent |
| unit_present | input | 2^(GRP_BITS+INST_BITS) | Per-unit presence mask |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | DATA_W | Read data, zero when not valid |

## Verification
The assertions assume that `unit_present` and the bus inputs are stable around the sampling edge, and that at most one request arrives per cycle, which the protocol already guarantees. They also assume that the presence mask seen in a read's request cycle is the one that decides the result. The bench therefore drives every input, including the presence mask, only on the falling edge before a request. It never changes the mask while a request is being sampled. The random phase picks agents, addresses, data and mask updates from a fixed seed, and a reference model predicts the result of every read.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_SEL  = 2'd1,
    ADDR_SEM  = 2'd2,
    ADDR_RSVD = 2'd3
  } mcr_addr_e;

  localparam int SEL_GRP_LSB = 8;
  localparam int SEL_MC_BIT  = 31;
endpackage

// File: rtl/mcr_semaphore.sv
module mcr_semaphore #(
  parameter int AGENT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_hit,
  input  logic               wr_hit,
  input  logic               wr_is_one,
  input  logic [AGENT_W-1:0] agent,
  output logic               held,
  output logic [AGENT_W-1:0] owner,
  output logic               grant
);
  logic release_ok;

  assign grant      = rd_hit && !held;
  assign release_ok = wr_hit && held && (owner == agent) && wr_is_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (grant) begin
      held  <= 1'b1;
      owner <= agent;
    end else if (release_ok) begin
      held  <= 1'b0;
    end
  end
endmodule

// File: rtl/mcr_selector.sv
module mcr_selector
  import mcr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GRP_BITS  = 1,
  parameter int INST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  output logic [GRP_BITS-1:0]  grp,
  output logic [INST_BITS-1:0] inst,
  output logic                 mcast,
  output logic [DATA_W-1:0]    sel_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp   <= '0;
      inst  <= '0;
      mcast <= 1'b1;
    end else if (wr_en) begin
      grp   <= wdata[SEL_GRP_LSB +: GRP_BITS];
      inst  <= wdata[INST_BITS-1:0];
      mcast <= wdata[SEL_MC_BIT];
    end
  end

  always_comb begin
    sel_word                          = '0;
    sel_word[INST_BITS-1:0]           = inst;
    sel_word[SEL_GRP_LSB +: GRP_BITS] = grp;
    sel_word[SEL_MC_BIT]              = mcast;
  end
endmodule

// File: rtl/mcr_inst_store.sv
module mcr_inst_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int N_UNITS = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               mcast,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_UNITS-1:0] present,
  output logic [DATA_W-1:0]  rd_val
);
  logic [DATA_W-1:0] copy_q [N_UNITS];

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic hit;
    assign hit = wr_en && present[u] && (mcast || (idx == IDX_W'(u)));
    always_ff @(posedge clk) begin
      if (!rst_n)   copy_q[u] <= '0;
      else if (hit) copy_q[u] <= wdata;
    end
  end

  assign rd_val = present[idx] ? copy_q[idx] : '0;
endmodule

// File: rtl/mcr_bank.sv
module mcr_bank
  import mcr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AGENT_W   = 2,
  parameter int GRP_BITS  = 1,
  parameter int INST_BITS = 2,
  localparam int IDX_W    = GRP_BITS + INST_BITS,
  localparam int N_UNITS  = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [AGENT_W-1:0] bus_agent,
  input  logic [N_UNITS-1:0] unit_present,
  output logic               bus_rvalid,
  output logic [DATA_W-1:0]  bus_rdata
);
  logic                 rd_req, wr_req;
  logic                 sem_held, sem_grant;
  logic [AGENT_W-1:0]   sem_owner;
  logic [GRP_BITS-1:0]  sel_grp;
  logic [INST_BITS-1:0] sel_inst;
  logic                 sel_mcast;
  logic [DATA_W-1:0]    sel_word;
  logic [IDX_W-1:0]     steer_idx;
  logic [DATA_W-1:0]    unit_rd;
  logic [DATA_W-1:0]    rd_mux;
  mcr_addr_e            addr_e;

  assign addr_e    = mcr_addr_e'(bus_addr);
  assign rd_req    = bus_req && !bus_we;
  assign wr_req    = bus_req && bus_we;
  assign steer_idx = {sel_grp, sel_inst};

  mcr_semaphore #(.AGENT_W(AGENT_W)) u_sem (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_req && addr_e == ADDR_SEM),
    .wr_hit    (wr_req && addr_e == ADDR_SEM),
    .wr_is_one (bus_wdata == DATA_W'(1)),
    .agent     (bus_agent),
    .held      (sem_held),
    .owner     (sem_owner),
    .grant     (sem_grant)
  );

  mcr_selector #(.DATA_W(DATA_W), .GRP_BITS(GRP_BITS), .INST_BITS(INST_BITS)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_req && addr_e == ADDR_SEL && sem_held && sem_owner == bus_agent),
    .wdata    (bus_wdata),
    .grp      (sel_grp),
    .inst     (sel_inst),
    .mcast    (sel_mcast),
    .sel_word (sel_word)
  );

  mcr_inst_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_req && addr_e == ADDR_DATA),
    .mcast   (sel_mcast),
    .idx     (steer_idx),
    .wdata   (bus_wdata),
    .present (unit_present),
    .rd_val  (unit_rd)
  );

  always_comb begin
    unique case (addr_e)
      ADDR_DATA: rd_mux = unit_rd;
      ADDR_SEL:  rd_mux = sel_word;
      ADDR_SEM:  rd_mux = DATA_W'(sem_grant);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mcr_bank_chk.sv
module mcr_bank_chk #(
  parameter int DATA_W  = 32,
  parameter int AGENT_W = 2,
  parameter int IDX_W   = 3,
  parameter int N_UNITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic [1:0]         bus_addr,
  input logic [AGENT_W-1:0] bus_agent,
  input logic [N_UNITS-1:0] unit_present,
  input logic               bus_rvalid,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               sem_held,
  input logic [AGENT_W-1:0] sem_owner,
  input logic [DATA_W-1:0]  sel_word,
  input logic [IDX_W-1:0]   steer_idx
);
  a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r11_no_rvalid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  a_r11_rdata_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> bus_rdata == '0);

  a_r4_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_held && bus_req && !bus_we && bus_addr == 2'd2) |=> (bus_rdata == '0 && sem_held));

  a_r4_free_read_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (!sem_held && bus_req && !bus_we && bus_addr == 2'd2)
      |=> (bus_rdata == DATA_W'(1) && sem_held && sem_owner == $past(bus_agent)));

  a_r3_foreign_sel_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == 2'd1 && !(sem_held && sem_owner == bus_agent))
      |=> $stable(sel_word));

  a_r9_absent_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr == 2'd0 && !unit_present[steer_idx]) |=> bus_rdata == '0);
endmodule

bind mcr_bank mcr_bank_chk #(
  .DATA_W(DATA_W), .AGENT_W(AGENT_W), .IDX_W(IDX_W), .N_UNITS(N_UNITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_agent    (bus_agent),
  .unit_present (unit_present),
  .bus_rvalid   (bus_rvalid),
  .bus_rdata    (bus_rdata),
  .sem_held     (sem_held),
  .sem_owner    (sem_owner),
  .sel_word     (sel_word),
  .steer_idx    (steer_idx)
);

// File: tb/tb_mcr_bank.sv
`timescale 1ns/1ps
module tb_mcr_bank;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int GB = 1;
  localparam int IB = 2;
  localparam int N  = 1 << (GB + IB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [AW-1:0] bus_agent = '0;
  logic [N-1:0]  unit_present = '1;
  logic          bus_rvalid;
  logic [DW-1:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_store [N];
  logic [GB-1:0] m_grp;
  logic [IB-1:0] m_inst;
  logic          m_mc;
  logic          m_held;
  logic [AW-1:0] m_owner;
  logic [DW-1:0] last_rd;

  always #2.5 clk = ~clk;

  mcr_bank #(.DATA_W(DW), .AGENT_W(AW), .GRP_BITS(GB), .INST_BITS(IB)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_agent(bus_agent), .unit_present(unit_present),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  function automatic logic [DW-1:0] sel_of(logic [GB-1:0] g, logic [IB-1:0] i, logic mc);
    logic [DW-1:0] w = '0;
    w[IB-1:0] = i;
    w[8 +: GB] = g;
    w[31] = mc;
    return w;
  endfunction

  function automatic logic [DW-1:0] model_read(logic [1:0] a);
    logic [GB+IB-1:0] ix = {m_grp, m_inst};
    case (a)
      2'd0: return unit_present[ix] ? m_store[ix] : '0;
      2'd1: return sel_of(m_grp, m_inst, m_mc);
      2'd2: return m_held ? '0 : DW'(1);
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) m_store[k] = '0;
    m_grp = '0; m_inst = '0; m_mc = 1'b1; m_held = 1'b0; m_owner = '0;
  endtask

  // One bus access; reads are checked against the model, and rvalid against R11.
  task automatic op(logic [AW-1:0] ag, logic we, logic [1:0] a, logic [DW-1:0] wd);
    logic [DW-1:0] exp;
    logic [GB+IB-1:0] ix;
    string tag;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; bus_agent = ag;
    exp = model_read(a);
    ix = {m_grp, m_inst};
    if (we) begin
      case (a)
        2'd0: for (int k = 0; k < N; k++)
                if (unit_present[k] && (m_mc || ix == k[GB+IB-1:0])) m_store[k] = wd;
        2'd1: if (m_held && m_owner == ag) begin
                m_grp = wd[8 +: GB]; m_inst = wd[IB-1:0]; m_mc = wd[31];
              end
        2'd2: if (m_held && m_owner == ag && wd == 1) m_held = 1'b0;
        default: ;
      endcase
    end else if (a == 2'd2 && !m_held) begin
      m_held = 1'b1; m_owner = ag;
    end
    @(negedge clk);
    bus_req = 1'b0;
    last_rd = bus_rdata;
    check("R11", {31'b0, bus_rvalid}, {31'b0, !we});
    if (!we) begin
      tag = (a == 2'd0) ? (unit_present[ix] ? "R8" : "R9") :
            (a == 2'd1) ? "R2" : (a == 2'd2) ? "R4" : "R11";
      check(tag, bus_rdata, exp);
    end else begin
      check("R11", bus_rdata, '0);
    end
  endtask

  task automatic steer(logic [AW-1:0] ag, logic [GB+IB-1:0] ix, logic mc);
    op(ag, 1'b1, 2'd1, sel_of(ix[GB+IB-1:IB], ix[IB-1:0], mc));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    op(0, 0, 2'd1, 0); check("R1", last_rd, 32'h8000_0000);
    op(0, 0, 2'd0, 0); check("R1", last_rd, 0);

    // R4: first reader wins, everyone else and the owner get 0
    op(2, 0, 2'd2, 0); check("R4", last_rd, 1);
    op(1, 0, 2'd2, 0); check("R4", last_rd, 0);
    op(2, 0, 2'd2, 0); check("R4", last_rd, 0);

    // R3: non-owner selector write ignored
    op(1, 1, 2'd1, 32'h0000_0103);
    op(1, 0, 2'd1, 0); check("R3", last_rd, 32'h8000_0000);

    // R2/R7: owner steers unicast to group 1 instance 2 (unit 6) and writes
    op(2, 1, 2'd1, 32'h0000_0102);
    op(2, 0, 2'd1, 0); check("R2", last_rd, 32'h0000_0102);
    op(2, 1, 2'd0, 32'h0000_AAAA);
    steer(2, 3'd1, 1'b0);
    op(2, 0, 2'd0, 0); check("R7", last_rd, 0);
    // R8: broadcast bit set, read still comes from unit 6
    steer(2, 3'd6, 1'b1);
    op(3, 0, 2'd0, 0); check("R8", last_rd, 32'h0000_AAAA);

    // R6/R10: broadcast with unit 3 absent
    @(negedge clk); unit_present = 8'hF7;
    op(2, 1, 2'd0, 32'h0000_5555);
    @(negedge clk); unit_present = 8'hFF;
    for (int k = 0; k < N; k++) begin
      steer(2, k[2:0], 1'b0);
      op(2, 0, 2'd0, 0);
      check(k == 3 ? "R10" : "R6", last_rd, k == 3 ? 32'h0 : 32'h5555);
    end

    // R9/R10: unit 5 absent, unicast dropped, read zero, value returns later
    steer(2, 3'd5, 1'b0);
    @(negedge clk); unit_present = 8'hDF;
    op(2, 1, 2'd0, 32'h0000_1234);
    op(2, 0, 2'd0, 0); check("R9", last_rd, 0);
    @(negedge clk); unit_present = 8'hFF;
    op(2, 0, 2'd0, 0); check("R10", last_rd, 32'h0000_5555);

    // R5: release rules
    op(1, 1, 2'd2, 1);
    op(0, 0, 2'd2, 0); check("R5", last_rd, 0);
    op(2, 1, 2'd2, 2);
    op(0, 0, 2'd2, 0); check("R5", last_rd, 0);
    op(2, 1, 2'd2, 1);
    op(0, 0, 2'd2, 0); check("R5", last_rd, 1);

    // R11: reserved address reads zero
    op(0, 0, 2'd3, 0); check("R11", last_rd, 0);

    // Random phase with a fixed seed
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 3000; it++) begin
      logic [AW-1:0] ag = AW'($urandom_range(0, 3));
      logic          we = 1'($urandom_range(0, 1));
      logic [1:0]    a  = 2'($urandom_range(0, 3));
      logic [DW-1:0] wd = $urandom();
      if ($urandom_range(0, 9) == 0) begin
        @(negedge clk); unit_present = N'($urandom());
      end
      if (a == 2'd2 && we && $urandom_range(0, 1) == 0) wd = 1;
      if (a == 2'd1 && we && m_held && $urandom_range(0, 1) == 0) ag = m_owner;
      op(ag, we, a, wd);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule